// File: doc/BRIEF.md
# Descriptor Ring Pointer Controller

This block sequences descriptor IDs around a circular table. Software sets the ring length and then names a target ID; every ID after the previous target, up to and including the new one, is handed in ascending order to a downstream engine. Past the highest valid ID the sequence wraps to zero. Each ID is handed over through a valid/ready handshake.

The engine reports each finished descriptor with a one-cycle completion pulse that carries the ID. When done reporting is enabled, the block raises one status-write strobe for each completion. It raises a single interrupt pulse once the whole outstanding batch has drained. The block also holds a 64-bit table base address, which is written in two halves. Fetching descriptors and moving data are handled elsewhere.

On the issue port, `issue_valid` stays high with `issue_id` held steady until `issue_ready` is seen. An ID is consumed only in a cycle where both are high. Holding `issue_ready` low stalls the sequence without losing or repeating any ID. The completion port has no back-pressure.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset, the table-size register reads 127, the target-pointer register reads 0xFF, the control and base registers read 0, `issue_valid` and `irq` are low, `pend_cnt` is 0 and `issue_ptr` is 0.
- R2: Register word index on `reg_addr`: 0 = base high half, 1 = base low half, 2 = target pointer, 3 = table size, 4 = control. The read port is combinational on `reg_addr`.
- R3: A write of value V to the target pointer queues every ID from the previous target plus one through V. It is ignored when V equals the current target. After reset the first ID issued is 0.
- R4: IDs step upward and return to 0 after the ID equal to the table-size value. Writing the top ID and then a small ID N continues through 0..N.
- R5: While `issue_valid` is high and `issue_ready` is low, `issue_valid` and `issue_id` hold. Exactly one ID is consumed per handshake, and issue stops after the ID equal to the target.
- R6: A target write while IDs are still pending extends the run from the current position. No ID is issued twice.
- R7: Reading the target pointer returns the last requested ID while `pend_cnt` is non-zero. It returns 0xFF when nothing is outstanding and while `rst_n` is low.
- R8: With control bit 0 set, every completion gives `stat_we` high for one cycle on the following cycle, with `stat_id` equal to the completed ID. With bit 0 clear, `stat_we` stays low.
- R9: With control bit 0 set, `irq` pulses for one cycle, one cycle after the completion that brings `pend_cnt` to zero. A run that is extended before it drains gives a single pulse. With bit 0 clear, there is no pulse.
- R10: A write to the base high half is only staged. `tbl_base` changes only on a write to the low half, which sets it to {staged high, written low}.
- R11: Control bits 31..1 read as 0, and writes to them have no effect.
- R12: A table-size write is taken only while `pend_cnt` is 0, and it resets the ring so that the next ID is 0. Table-size writes while busy are ignored, and target writes above the table size are ignored.
- R13: `issue_ptr` is the next ID to be issued. `pend_cnt` counts the IDs not yet issued plus the IDs issued but not yet completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| issue_valid | output | 1 | An ID is offered downstream |
| issue_ready | input | 1 | Downstream accepts the offered ID |
| issue_id | output | 8 | Offered descriptor ID |
| cmpl_valid | input | 1 | Completion pulse |
| cmpl_id | input | 8 | ID of the completed descriptor |
| stat_we | output | 1 | Per-descriptor status write strobe |
| stat_id | output | 8 | ID for the status write |
| irq | output | 1 | One-cycle batch interrupt |
| tbl_base | output | 64 | Committed table base address |
| issue_ptr | output | 8 | Next ID to issue |
| pend_cnt | output | 10 | Outstanding descriptor count |

## Verification
The assertions take for granted that the engine never reports a completion while nothing is in flight. They also assume that software writes the table size only when the ring is idle, which the block enforces. The stimulus meets the first assumption by completing only IDs that it has already taken through a handshake, and by completing them before it records the handshake of the same cycle. Control writes happen only when the ring is idle, so every completion is judged against one known enable setting. Ready and completion follow fixed cyclic patterns, so stalls fall both mid-run and across the wrap.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  typedef logic [31:0] word_t;
  localparam logic [2:0] RA_BASE_HI = 3'd0;
  localparam logic [2:0] RA_BASE_LO = 3'd1;
  localparam logic [2:0] RA_LAST    = 3'd2;
  localparam logic [2:0] RA_TSIZE   = 3'd3;
  localparam logic [2:0] RA_CTRL    = 3'd4;
  localparam word_t      IDLE_READ  = 32'h0000_00FF;
endpackage

// File: rtl/desc_ring_regs.sv
module desc_ring_regs
  import desc_ring_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int TSIZE_RST = 127
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  word_t           reg_wdata,
  output word_t           reg_rdata,
  input  logic            busy,
  input  logic [ID_W-1:0] tail,
  output logic [ID_W-1:0] tsize,
  output logic            done_en,
  output logic [63:0]     tbl_base,
  output logic            lp_wr,
  output logic [ID_W-1:0] lp_val,
  output logic            ts_wr,
  output logic [ID_W-1:0] ts_val
);
  localparam int PAD = 32 - ID_W;

  word_t           hi_stage_q;
  logic [63:0]     base_q;
  logic [ID_W-1:0] tsize_q;
  logic            den_q;

  assign lp_val = reg_wdata[ID_W-1:0];
  assign ts_val = reg_wdata[ID_W-1:0];
  assign lp_wr  = reg_we && (reg_addr == RA_LAST) &&
                  (reg_wdata <= {{PAD{1'b0}}, tsize_q});
  assign ts_wr  = reg_we && (reg_addr == RA_TSIZE) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_stage_q <= '0;
      base_q     <= '0;
      tsize_q    <= ID_W'(TSIZE_RST);
      den_q      <= 1'b0;
    end else begin
      if (reg_we && reg_addr == RA_BASE_HI) hi_stage_q <= reg_wdata;
      if (reg_we && reg_addr == RA_BASE_LO) base_q <= {hi_stage_q, reg_wdata};
      if (ts_wr) tsize_q <= ts_val;
      if (reg_we && reg_addr == RA_CTRL) den_q <= reg_wdata[0];
    end
  end

  always_comb begin
    case (reg_addr)
      RA_BASE_HI: reg_rdata = hi_stage_q;
      RA_BASE_LO: reg_rdata = base_q[31:0];
      RA_LAST:    reg_rdata = (busy && rst_n) ? {{PAD{1'b0}}, tail} : IDLE_READ;
      RA_TSIZE:   reg_rdata = {{PAD{1'b0}}, tsize_q};
      RA_CTRL:    reg_rdata = {31'b0, den_q};
      default:    reg_rdata = '0;
    endcase
  end

  assign tsize    = tsize_q;
  assign done_en  = den_q;
  assign tbl_base = base_q;

  // R10
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == RA_BASE_LO) |=> $stable(tbl_base));
  // R12
  tsize_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tsize));
endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq #(
  parameter int ID_W      = 8,
  parameter int CNT_W     = 10,
  parameter int TSIZE_RST = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  tsize,
  input  logic             lp_wr,
  input  logic [ID_W-1:0]  lp_val,
  input  logic             ts_wr,
  input  logic [ID_W-1:0]  ts_val,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [ID_W-1:0]  issue_id,
  input  logic             cmpl_valid,
  output logic [ID_W-1:0]  tail,
  output logic [ID_W-1:0]  issue_ptr,
  output logic [CNT_W-1:0] pend_cnt,
  output logic             batch_end
);
  localparam int DW = ID_W + 1;

  logic [ID_W-1:0]  tail_q, nxt_q;
  logic [CNT_W-1:0] todo_q, infl_q;
  logic [DW-1:0]    gap;
  logic             hs;

  always_comb begin
    gap = '0;
    if (lp_wr && lp_val != tail_q) begin
      if (lp_val > tail_q) gap = {1'b0, lp_val} - {1'b0, tail_q};
      else gap = {1'b0, lp_val} + {1'b0, tsize} + DW'(1) - {1'b0, tail_q};
    end
  end

  assign issue_valid = (todo_q != '0);
  assign issue_id    = nxt_q;
  assign hs          = issue_valid && issue_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q <= ID_W'(TSIZE_RST);
      nxt_q  <= '0;
      todo_q <= '0;
      infl_q <= '0;
    end else begin
      todo_q <= todo_q + {{(CNT_W-DW){1'b0}}, gap} - CNT_W'(hs);
      infl_q <= infl_q + CNT_W'(hs) - CNT_W'(cmpl_valid);
      if (ts_wr) begin
        tail_q <= ts_val;
        nxt_q  <= '0;
      end else begin
        if (lp_wr) tail_q <= lp_val;
        if (hs) nxt_q <= (nxt_q == tsize) ? '0 : nxt_q + 1'b1;
      end
    end
  end

  assign tail      = tail_q;
  assign issue_ptr = nxt_q;
  assign pend_cnt  = todo_q + infl_q;
  assign batch_end = cmpl_valid && (infl_q == CNT_W'(1)) && (todo_q == '0) && (gap == '0);

  // R5
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_ready |=> issue_valid && $stable(issue_id));
  // R4
  id_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> issue_id <= tsize);
  // R13
  pend_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !cmpl_valid && gap == '0 |=> pend_cnt == $past(pend_cnt));
  // R13
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hs && !ts_wr |=> $stable(issue_ptr));
  // R8: completions only for IDs in flight
  cmpl_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |-> infl_q != '0);
endmodule

// File: rtl/desc_ring_done.sv
module desc_ring_done #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_en,
  input  logic            cmpl_valid,
  input  logic [ID_W-1:0] cmpl_id,
  input  logic            batch_end,
  output logic            stat_we,
  output logic [ID_W-1:0] stat_id,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_we <= 1'b0;
      stat_id <= '0;
      irq     <= 1'b0;
    end else begin
      stat_we <= cmpl_valid && done_en;
      stat_id <= cmpl_id;
      irq     <= batch_end && done_en;
    end
  end

  // R8
  stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> $past(cmpl_valid) && stat_id == $past(cmpl_id));
  // R8
  stat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid && !done_en |=> !stat_we);
  // R9
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(done_en));
  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int ID_W      = 8,
  parameter int TSIZE_RST = 127,
  localparam int CNT_W    = ID_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [ID_W-1:0]  issue_id,
  input  logic             cmpl_valid,
  input  logic [ID_W-1:0]  cmpl_id,
  output logic             stat_we,
  output logic [ID_W-1:0]  stat_id,
  output logic             irq,
  output logic [63:0]      tbl_base,
  output logic [ID_W-1:0]  issue_ptr,
  output logic [CNT_W-1:0] pend_cnt
);
  logic [ID_W-1:0] tsize, tail, lp_val, ts_val;
  logic            done_en, lp_wr, ts_wr, batch_end;

  desc_ring_regs #(.ID_W(ID_W), .TSIZE_RST(TSIZE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(pend_cnt != '0),
    .tail(tail), .tsize(tsize), .done_en(done_en), .tbl_base(tbl_base),
    .lp_wr(lp_wr), .lp_val(lp_val), .ts_wr(ts_wr), .ts_val(ts_val)
  );

  desc_ring_seq #(.ID_W(ID_W), .CNT_W(CNT_W), .TSIZE_RST(TSIZE_RST)) u_seq (
    .clk(clk), .rst_n(rst_n), .tsize(tsize), .lp_wr(lp_wr), .lp_val(lp_val),
    .ts_wr(ts_wr), .ts_val(ts_val), .issue_valid(issue_valid),
    .issue_ready(issue_ready), .issue_id(issue_id), .cmpl_valid(cmpl_valid),
    .tail(tail), .issue_ptr(issue_ptr), .pend_cnt(pend_cnt), .batch_end(batch_end)
  );

  desc_ring_done #(.ID_W(ID_W)) u_done (
    .clk(clk), .rst_n(rst_n), .done_en(done_en), .cmpl_valid(cmpl_valid),
    .cmpl_id(cmpl_id), .batch_end(batch_end), .stat_we(stat_we),
    .stat_id(stat_id), .irq(irq)
  );

  // R9
  irq_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend_cnt == '0);
endmodule

// File: tb/sim_desc_ring_ctrl.sv
module sim_desc_ring_ctrl;
  import desc_ring_pkg::*;
  localparam int ID_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            reg_we = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            issue_valid;
  logic            issue_ready = 1'b0;
  logic [ID_W-1:0] issue_id;
  logic            cmpl_valid = 1'b0;
  logic [ID_W-1:0] cmpl_id = '0;
  logic            stat_we;
  logic [ID_W-1:0] stat_id;
  logic            irq;
  logic [63:0]     tbl_base;
  logic [ID_W-1:0] issue_ptr;
  logic [ID_W+1:0] pend_cnt;

  desc_ring_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .issue_valid(issue_valid),
    .issue_ready(issue_ready), .issue_id(issue_id), .cmpl_valid(cmpl_valid),
    .cmpl_id(cmpl_id), .stat_we(stat_we), .stat_id(stat_id), .irq(irq),
    .tbl_base(tbl_base), .issue_ptr(issue_ptr), .pend_cnt(pend_cnt)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, irq_seen = 0, stat_seen = 0;
  int m_tail = 127, m_tsize = 127;
  logic den_m = 1'b0, fin = 1'b0;
  logic [ID_W-1:0] exp_q[$];
  logic [ID_W-1:0] fly_q[$];
  logic prev_c = 1'b0, prev_stall = 1'b0;
  logic [ID_W-1:0] prev_cid = '0, prev_sid = '0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // driver: computes the expected ID sequence, then writes the target
  task automatic request(int v);
    if (v <= m_tsize && v != m_tail) begin
      int id = m_tail;
      do begin
        id = (id == m_tsize) ? 0 : id + 1;
        exp_q.push_back(id[ID_W-1:0]);
      end while (id != v);
      m_tail = v;
    end
    wr(RA_LAST, v);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || fly_q.size() != 0 || pend_cnt != 0);
    repeat (3) @(negedge clk);
  endtask

  // monitor and downstream model
  always @(negedge clk) begin
    logic [ID_W-1:0] e;
    if (rst_n) begin
      cyc++;
      if (prev_stall) chk("R5 hold under stall", {55'b0, issue_valid, issue_id}, {55'b0, 1'b1, prev_sid});
      if (stat_we || (prev_c && den_m))
        chk("R8 status strobe", {55'b0, stat_we, stat_id}, {55'b0, prev_c && den_m, prev_cid});
      if (stat_we) stat_seen++;
      if (irq) irq_seen++;
      prev_c = 1'b0;
      cmpl_valid = 1'b0;
      if (fly_q.size() > 0 && (cyc % 3) != 1) begin
        cmpl_id = fly_q.pop_front();
        cmpl_valid = 1'b1;
        prev_c = 1'b1;
        prev_cid = cmpl_id;
      end
      issue_ready = (cyc % 5) != 3;
      prev_stall = issue_valid && !issue_ready;
      prev_sid = issue_id;
      if (issue_valid && issue_ready) begin
        if (exp_q.size() == 0) chk("R5 no issue past target", 64'(issue_id) + 64'h100, 64'h0);
        else begin
          e = exp_q.pop_front();
          chk("R3 R4 R6 issue order", 64'(issue_id), 64'(e));
          fly_q.push_back(issue_id);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rd(RA_LAST, d);  chk("R7 sentinel in reset", 64'(d), 64'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    rd(RA_LAST, d);  chk("R1 target idle", 64'(d), 64'hFF);
    rd(RA_TSIZE, d); chk("R1 table size", 64'(d), 64'd127);
    rd(RA_CTRL, d);  chk("R1 control", 64'(d), 64'd0);
    chk("R1 outputs", {tbl_base}, 64'd0);
    chk("R1 flags", {44'b0, issue_valid, irq, pend_cnt, issue_ptr}, 64'd0);

    wr(RA_BASE_HI, 32'h1234_5678);
    chk("R10 high staged only", tbl_base, 64'd0);
    rd(RA_BASE_HI, d); chk("R10 high readback", 64'(d), 64'h1234_5678);
    wr(RA_BASE_LO, 32'h9ABC_DEF0);
    chk("R10 commit", tbl_base, 64'h1234_5678_9ABC_DEF0);

    wr(RA_CTRL, 32'hFFFF_FFFF);
    den_m = 1'b1;
    rd(RA_CTRL, d); chk("R11 upper bits zero", 64'(d), 64'd1);

    request(4);
    rd(RA_LAST, d); chk("R7 target while busy", 64'(d), 64'd4);
    chk("R13 pending after write", 64'(pend_cnt), 64'd5);
    wait_idle();
    chk("R9 one irq for batch", 64'(irq_seen), 64'd1);
    chk("R8 status count", 64'(stat_seen), 64'd5);
    rd(RA_LAST, d); chk("R7 idle sentinel", 64'(d), 64'hFF);
    chk("R13 next pointer", 64'(issue_ptr), 64'd5);

    request(10);
    request(15);
    wait_idle();
    chk("R6 R9 extended run one irq", 64'(irq_seen), 64'd2);
    chk("R8 status count extended", 64'(stat_seen), 64'd16);

    wr(RA_TSIZE, 32'd20);
    m_tsize = 20; m_tail = 20;
    rd(RA_TSIZE, d); chk("R12 size taken idle", 64'(d), 64'd20);
    chk("R12 ring restarts at 0", 64'(issue_ptr), 64'd0);
    request(30);
    repeat (2) @(negedge clk);
    chk("R12 over-range target ignored", {62'b0, issue_valid, pend_cnt != 0}, 64'd0);

    request(18);
    wr(RA_TSIZE, 32'd5);
    rd(RA_TSIZE, d); chk("R12 size ignored while busy", 64'(d), 64'd20);
    wait_idle();
    request(20);
    request(2);
    wait_idle();
    chk("R4 wrap batch irq count", 64'(irq_seen), 64'd4);
    chk("R4 pointer after wrap", 64'(issue_ptr), 64'd3);

    wr(RA_CTRL, 32'hFFFF_FFFE);
    den_m = 1'b0;
    rd(RA_CTRL, d); chk("R11 upper bits ignored", 64'(d), 64'd0);
    d = 32'(stat_seen);
    request(6);
    wait_idle();
    chk("R9 no irq when disabled", 64'(irq_seen), 64'd4);
    chk("R8 no status when disabled", 64'(stat_seen), 64'(d));
    chk("R2 R13 pointer after run", 64'(issue_ptr), 64'd7);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule